// File: doc/BRIEF.md
# Branch Displacement and Target Decoder

This block takes instruction words one per cycle from a stream and picks out the control-transfer forms of a 16-bit-opcode instruction set. These are the conditional branch, the branch-to-subroutine, and the decrement-and-branch loop form. The first word of each instruction is its opcode, and the address presented with that word is the instruction's address. Any extension words the opcode calls for follow in later valid cycles. Idle cycles between words are allowed.

Once the final word of an instruction has been taken, the block reports the following for one cycle:

- the operation class;
- the 4-bit condition;
- how the displacement was encoded;
- the displacement, sign-extended to the address width;
- the branch target;
- the loop counter register;
- the number of words consumed.

In the same group as the loop form, the block also recognises the add-quick and subtract-quick forms and expands their 3-bit immediate. The block does not evaluate conditions, push return addresses or decrement counters.

Top module: `branch_target_decoder`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid` is 0 and all outputs are 0. A reset in the middle of an instruction discards the partially received words, so the next word is treated as an opcode.
- R2: An opcode whose bits 15..12 equal 6 is a branch. `out_cond` equals opcode bits 11..8. `out_kind` is 2 (subroutine) when that value is 1, and 1 (conditional branch) for every other value.
- R3: For a branch whose low byte is neither 0x00 nor 0xFF, the result has `out_variant` = 1 and `out_words` = 1, and `out_disp` is the low byte sign-extended.
- R4: For a branch whose low byte is 0x00, the next word is the displacement. The result has `out_variant` = 2 and `out_words` = 2, and `out_disp` is that word sign-extended from 16 bits.
- R5: For a branch whose low byte is 0xFF, the next two words form the displacement, upper half first. The result has `out_variant` = 3 and `out_words` = 3, and `out_disp` is {first, second}.
- R6: `out_target` equals the instruction address plus 2 plus `out_disp`, modulo 2^ADDR_W. Forms without a displacement report `out_disp` = 0 and `out_variant` = 0.
- R7: An opcode is the loop form when bits 15..12 = 5, bits 7..6 = 3 and bits 5..3 = 1. It reports `out_kind` = 3, `out_cond` = bits 11..8, `out_reg` = bits 2..0, `out_variant` = 2 and `out_words` = 2, and `out_disp` is the following word sign-extended. For every other kind, `out_reg` is 0.
- R8: An opcode with bits 15..12 = 5 and bits 7..6 not equal to 3 is a quick form. It reports `out_kind` = 5 when bit 8 is 1 and 4 when bit 8 is 0. `out_quick` is bits 11..9, with 0 read as 8. It also reports `out_words` = 1 and `out_cond` = 0. For every other kind, `out_quick` is 0.
- R9: Any other opcode, including group 5 with bits 7..6 = 3 and bits 5..3 not equal to 1, reports `out_kind` = 0, `out_words` = 1, `out_cond` = 0 and `out_variant` = 0.
- R10: `out_valid` is high for exactly one cycle per instruction, on the cycle after its final word is accepted. It stays low while extension words are awaited, including across idle cycles between words.
- R11: Only the `in_addr` value presented with the opcode word is used. The `in_addr` values presented with extension words have no effect on `out_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream word is present this cycle |
| in_word | input | 16 | Stream word (opcode or extension) |
| in_addr | input | ADDR_W | Address of the instruction, used with its opcode word |
| out_valid | output | 1 | Decoded result present (one cycle) |
| out_kind | output | 3 | 0 other, 1 conditional branch, 2 subroutine, 3 loop, 4 add quick, 5 subtract quick |
| out_cond | output | 4 | Condition field |
| out_variant | output | 2 | 0 none, 1 short, 2 one word, 3 two words |
| out_disp | output | ADDR_W | Sign-extended displacement |
| out_target | output | ADDR_W | Instruction address + 2 + displacement |
| out_reg | output | 3 | Loop counter register number |
| out_quick | output | 4 | Quick immediate, 1 to 8 |
| out_words | output | 2 | Words consumed including the opcode |

## Verification
The bench builds the block with ADDR_W = 32, the width at which the two-word displacement fills the address exactly. This lets the bench check every carry out of the target adder against plain 32-bit arithmetic, including wrap past the top of the address space. It sweeps all 256 values of the branch low byte, so both escape codes and every short displacement are covered. It also sweeps every condition and counter register of the loop form, and every immediate, direction and size of the quick form. Idle gaps and changing addresses are inserted between extension words, and a reset is applied partway through an instruction.

// File: rtl/bdec_pkg.sv
package bdec_pkg;
  localparam int WORD_W = 16;

  localparam logic [3:0] GRP_BRANCH = 4'h6;
  localparam logic [3:0] GRP_QUICK  = 4'h5;
  localparam logic [3:0] COND_CALL  = 4'h1;
  localparam logic [7:0] ESC_WORD   = 8'h00;
  localparam logic [7:0] ESC_LONG   = 8'hFF;
  localparam logic [1:0] SZ_NOSIZE  = 2'b11;
  localparam logic [2:0] MODE_LOOP  = 3'b001;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_BCC   = 3'd1,
    K_BSR   = 3'd2,
    K_LOOP  = 3'd3,
    K_QADD  = 3'd4,
    K_QSUB  = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    V_NONE  = 2'd0,
    V_SHORT = 2'd1,
    V_WORD  = 2'd2,
    V_LONG  = 2'd3
  } vsize_e;

  typedef struct packed {
    kind_e       kind;
    logic [3:0]  cond;
    vsize_e      vsize;
    logic [1:0]  ext;
    logic [2:0]  creg;
    logic [3:0]  quick;
  } op_info_t;
endpackage

// File: rtl/bdec_classify.sv
module bdec_classify
  import bdec_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  output op_info_t          info
);
  always_comb begin
    info       = '0;
    info.kind  = K_OTHER;
    info.vsize = V_NONE;
    case (op[15:12])
      GRP_BRANCH: begin
        info.cond = op[11:8];
        info.kind = (op[11:8] == COND_CALL) ? K_BSR : K_BCC;
        if (op[7:0] == ESC_WORD) begin
          info.vsize = V_WORD;
          info.ext   = 2'd1;
        end else if (op[7:0] == ESC_LONG) begin
          info.vsize = V_LONG;
          info.ext   = 2'd2;
        end else begin
          info.vsize = V_SHORT;
          info.ext   = 2'd0;
        end
      end
      GRP_QUICK: begin
        if (op[7:6] == SZ_NOSIZE) begin
          if (op[5:3] == MODE_LOOP) begin
            info.kind  = K_LOOP;
            info.cond  = op[11:8];
            info.creg  = op[2:0];
            info.vsize = V_WORD;
            info.ext   = 2'd1;
          end
        end else begin
          info.kind  = op[8] ? K_QSUB : K_QADD;
          info.quick = (op[11:9] == 3'd0) ? 4'd8 : {1'b0, op[11:9]};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bdec_disp.sv
module bdec_disp
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  vsize_e            vsize,
  input  logic [7:0]        short8,
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  output logic [ADDR_W-1:0] disp
);
  localparam int LONG_W = 2 * WORD_W;

  logic [ADDR_W-1:0] sx_short;
  logic [ADDR_W-1:0] sx_word;
  logic [ADDR_W-1:0] sx_long;

  assign sx_short = {{(ADDR_W-8){short8[7]}}, short8};
  assign sx_word  = {{(ADDR_W-WORD_W){lo[WORD_W-1]}}, lo};

  generate
    if (ADDR_W == LONG_W) begin : g_exact
      assign sx_long = {hi, lo};
    end else begin : g_wide
      assign sx_long = {{(ADDR_W-LONG_W){hi[WORD_W-1]}}, hi, lo};
    end
  endgenerate

  always_comb begin
    case (vsize)
      V_SHORT: disp = sx_short;
      V_WORD:  disp = sx_word;
      V_LONG:  disp = sx_long;
      default: disp = '0;
    endcase
  end
endmodule

// File: rtl/bdec_seq.sv
module bdec_seq
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        need,
  output logic [1:0]        idx,
  output logic              fire,
  output logic [WORD_W-1:0] held_op,
  output logic [ADDR_W-1:0] held_addr,
  output logic [WORD_W-1:0] held_ext
);
  assign fire = in_valid && (idx == need);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= 2'd0;
      held_op   <= '0;
      held_addr <= '0;
      held_ext  <= '0;
    end else if (in_valid) begin
      if (idx == 2'd0) begin
        held_op   <= in_word;
        held_addr <= in_addr;
      end
      if (idx == 2'd1) begin
        held_ext <= in_word;
      end
      idx <= fire ? 2'd0 : 2'(idx + 2'd1);
    end
  end
endmodule

// File: rtl/branch_target_decoder.sv
module branch_target_decoder
  import bdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [15:0]       in_word,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [2:0]        out_kind,
  output logic [3:0]        out_cond,
  output logic [1:0]        out_variant,
  output logic [ADDR_W-1:0] out_disp,
  output logic [ADDR_W-1:0] out_target,
  output logic [2:0]        out_reg,
  output logic [3:0]        out_quick,
  output logic [1:0]        out_words
);
  localparam logic [ADDR_W-1:0] OP_BYTES = ADDR_W'(2);

  logic [1:0]        idx;
  logic              fire;
  logic [WORD_W-1:0] held_op;
  logic [ADDR_W-1:0] held_addr;
  logic [WORD_W-1:0] held_ext;
  logic [WORD_W-1:0] cur_op;
  logic [ADDR_W-1:0] cur_addr;
  op_info_t          info;
  logic [ADDR_W-1:0] disp;
  logic [ADDR_W-1:0] target;

  assign cur_op   = (idx == 2'd0) ? in_word : held_op;
  assign cur_addr = (idx == 2'd0) ? in_addr : held_addr;

  bdec_classify u_cls (
    .op   (cur_op),
    .info (info)
  );

  bdec_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_addr   (in_addr),
    .need      (info.ext),
    .idx       (idx),
    .fire      (fire),
    .held_op   (held_op),
    .held_addr (held_addr),
    .held_ext  (held_ext)
  );

  bdec_disp #(.ADDR_W(ADDR_W)) u_disp (
    .vsize  (info.vsize),
    .short8 (cur_op[7:0]),
    .hi     (held_ext),
    .lo     (in_word),
    .disp   (disp)
  );

  assign target = cur_addr + OP_BYTES + disp;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_kind    <= '0;
      out_cond    <= '0;
      out_variant <= '0;
      out_disp    <= '0;
      out_target  <= '0;
      out_reg     <= '0;
      out_quick   <= '0;
      out_words   <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_kind    <= info.kind;
        out_cond    <= info.cond;
        out_variant <= info.vsize;
        out_disp    <= disp;
        out_target  <= target;
        out_reg     <= info.creg;
        out_quick   <= info.quick;
        out_words   <= 2'(info.ext + 2'd1);
      end
    end
  end
endmodule

// File: rtl/bdec_chk.sv
module bdec_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [2:0]        out_kind,
  input logic [3:0]        out_cond,
  input logic [1:0]        out_variant,
  input logic [ADDR_W-1:0] out_disp,
  input logic [2:0]        out_reg,
  input logic [3:0]        out_quick,
  input logic [1:0]        out_words
);
  // R2
  bsr_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 3'd2) |-> out_cond == 4'd1);

  // R3
  short_words_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_variant == 2'd1) |-> (out_words == 2'd1 &&
      (out_disp[ADDR_W-1:7] == '0 || out_disp[ADDR_W-1:7] == '1)));

  // R4
  word_words_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_variant == 2'd2) |-> out_words == 2'd2);

  // R5
  long_words_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_variant == 2'd3) |-> out_words == 2'd3);

  // R6
  no_disp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_variant == 2'd0) |-> out_disp == '0);

  // R7
  reg_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind != 3'd3) |-> out_reg == 3'd0);

  // R8
  quick_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_kind == 3'd4 || out_kind == 3'd5)) |->
      (out_quick >= 4'd1 && out_quick <= 4'd8 && out_variant == 2'd0));

  // R10
  valid_follows_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

bind branch_target_decoder bdec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_kind    (out_kind),
  .out_cond    (out_cond),
  .out_variant (out_variant),
  .out_disp    (out_disp),
  .out_reg     (out_reg),
  .out_quick   (out_quick),
  .out_words   (out_words)
);

// File: tb/branch_target_decoder_tb.sv
module branch_target_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic [2:0]  out_kind;
  logic [3:0]  out_cond;
  logic [1:0]  out_variant;
  logic [31:0] out_disp;
  logic [31:0] out_target;
  logic [2:0]  out_reg;
  logic [3:0]  out_quick;
  logic [1:0]  out_words;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  branch_target_decoder #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_addr(in_addr), .out_valid(out_valid), .out_kind(out_kind),
    .out_cond(out_cond), .out_variant(out_variant), .out_disp(out_disp),
    .out_target(out_target), .out_reg(out_reg), .out_quick(out_quick),
    .out_words(out_words)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx8(input logic [7:0] v);
    return (v >= 8'h80) ? 32'(v) - 32'h100 : 32'(v);
  endfunction

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return (v >= 16'h8000) ? 32'(v) - 32'h10000 : 32'(v);
  endfunction

  // Independent model and drive of one instruction
  task automatic run(input logic [15:0] w0, input logic [15:0] w1,
                     input logic [15:0] w2, input logic [31:0] addr, input bit gap);
    int n = 1;
    logic [2:0]  e_kind = 3'd0;
    logic [3:0]  e_cond = 4'd0;
    logic [1:0]  e_var  = 2'd0;
    logic [31:0] e_disp = 32'd0;
    logic [2:0]  e_reg  = 3'd0;
    logic [3:0]  e_q    = 4'd0;
    string tag = "R9";
    if (w0[15:12] == 4'd6) begin
      e_cond = w0[11:8];
      e_kind = (w0[11:8] == 4'd1) ? 3'd2 : 3'd1;
      if (w0[7:0] == 8'h00) begin n = 2; e_var = 2'd2; e_disp = sx16(w1); tag = "R4"; end
      else if (w0[7:0] == 8'hFF) begin n = 3; e_var = 2'd3; e_disp = {w1, w2}; tag = "R5"; end
      else begin e_var = 2'd1; e_disp = sx8(w0[7:0]); tag = "R3"; end
    end else if (w0[15:12] == 4'd5 && w0[7:6] == 2'd3 && w0[5:3] == 3'd1) begin
      n = 2; e_kind = 3'd3; e_cond = w0[11:8]; e_reg = w0[2:0];
      e_var = 2'd2; e_disp = sx16(w1); tag = "R7";
    end else if (w0[15:12] == 4'd5 && w0[7:6] != 2'd3) begin
      e_kind = w0[8] ? 3'd5 : 3'd4;
      e_q = (w0[11:9] == 3'd0) ? 4'd8 : {1'b0, w0[11:9]};
      tag = "R8";
    end
    in_valid = 1'b1; in_word = w0; in_addr = addr;
    @(posedge clk); #1;
    for (int k = 1; k < n; k++) begin
      chk("R10 valid early", 32'(out_valid), 32'd0);
      if (gap) begin
        in_valid = 1'b0; in_word = 16'hDEAD; in_addr = ~addr;
        @(posedge clk); #1;
        chk("R10 valid in gap", 32'(out_valid), 32'd0);
      end
      in_valid = 1'b1; in_word = (k == 1) ? w1 : w2; in_addr = addr ^ 32'h5A5A_0F0F;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    chk("R10 valid", 32'(out_valid), 32'd1);
    chk({tag, " kind R2"}, 32'(out_kind), 32'(e_kind));
    chk({tag, " cond R2"}, 32'(out_cond), 32'(e_cond));
    chk({tag, " variant"}, 32'(out_variant), 32'(e_var));
    chk({tag, " disp"}, out_disp, e_disp);
    chk("R6 R11 target", out_target, addr + 32'd2 + e_disp);
    chk("R7 reg", 32'(out_reg), 32'(e_reg));
    chk("R8 quick", 32'(out_quick), 32'(e_q));
    chk({tag, " words"}, 32'(out_words), 32'(n));
    @(posedge clk); #1;
    chk("R10 pulse", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", 32'(out_valid), 32'd0);
    chk("R1 words", 32'(out_words), 32'd0);
    chk("R1 target", out_target, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after release", 32'(out_valid), 32'd0);

    // R1: reset part way through a long-displacement branch
    in_valid = 1'b1; in_word = 16'h62FF; in_addr = 32'h1000;
    @(posedge clk); #1;
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk("R1 mid reset", 32'(out_valid), 32'd0);
    run(16'h4E71, 16'h0000, 16'h0000, 32'h2000, 1'b0);

    // R2 R3 R4 R5: every branch low byte, condition varied
    for (int c = 0; c < 256; c++) begin
      logic [15:0] op = {4'h6, 4'(c), 8'(c)};
      run(op, 16'(c * 16'h0101) ^ 16'h8001, 16'(~c * 16'h0307),
          32'(c) * 32'h0101_0104 + 32'h0000_0100, (c % 3) == 0);
    end
    // R4 R5 R6: word and long forms with varied values, including wrap
    for (int k = 0; k < 16; k++) begin
      run(16'h6700, 16'(k * 16'h1111), 16'h0, 32'hFFFF_FF00 + 32'(k * 16), k[0]);
      run(16'h61FF, 16'(k * 16'h1001), 16'(k * 16'h2345),
          32'hFFFF_FFF0 - 32'(k * 64), k[1]);
    end
    run(16'h6000, 16'h7FFF, 16'h0, 32'hFFFF_FFFE, 1'b0);
    run(16'h60FF, 16'h8000, 16'h0000, 32'h0000_0004, 1'b1);

    // R7: loop form, every condition and counter register
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 8; r++)
        run({4'h5, 4'(c), 8'hC8 | 8'(r)}, 16'(c * 16'h0F01 + r * 16'h1234),
            16'h0, 32'(c * 256 + r * 2), (r % 4) == 1);

    // R8: quick forms, every immediate, direction and size
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 2; s++)
        for (int z = 0; z < 3; z++)
          run({4'h5, 3'(d), 1'(s), 2'(z), 6'(d * 5)}, 16'h0, 16'h0,
              32'h0040_0000 + 32'(d), 1'b0);

    // R9: other opcodes, including group 5 size 3 non-loop modes
    run(16'h57C0, 16'h0, 16'h0, 32'h10, 1'b0);
    run(16'h5AF9, 16'h0, 16'h0, 32'h20, 1'b0);
    run(16'h0000, 16'h0, 16'h0, 32'h30, 1'b0);
    run(16'hFFFF, 16'h0, 16'h0, 32'hFFFF_FFFE, 1'b0);
    run(16'h7F00, 16'h0, 16'h0, 32'h40, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule